// File: doc/BRIEF.md
# Triple-Redundant Readout Sequencer

This block is a small controller state machine hardened against single-event upsets by triplication. Its complete register set (a length setting held as configuration and the sequencer phase and word counter) exists in three copies. Every clock, a bitwise 2-of-3 majority of the three copies forms one voted state. All three copies compute their next value from that voted state, not from their own. A copy that an upset has corrupted is therefore rewritten with the correct value at the next edge. Each copy also drives its own output vector. A second majority stage votes those vectors onto the ports, so a single bad copy never reaches the outputs.

The sequencer serves as the example controller. A start pulse makes it emit one packet on a valid/ready stream: a header word, then a configurable number of body words, then a trailer word. A word moves only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the current word stays on the port unchanged and the sequencer waits. `mismatch` goes high whenever the three copies disagree. A fault-injection port lets a testbench XOR a bit mask into one chosen copy as that copy is written. The stream payload is only the phase and index, so no data path is protected.

Top module: `tmr_seq_top`

## Requirements
- R1: During and right after reset, `out_valid`, `out_kind`, `out_idx`, `busy` and `mismatch` are all 0. The length setting resets to `DEF_LEN`.
- R2: When idle, a `start` seen at an edge makes `busy` high and presents the header word from the next cycle on. A `start` given while busy has no effect on the packet in progress.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_kind` and `out_idx` keep their values.
- R4: A packet is a header (`out_kind`=1, `out_idx`=0), then L body words (`out_kind`=2, `out_idx` counting 0 to L-1), then a trailer (`out_kind`=3, `out_idx`=0). Here L is the length setting. L=0 gives a header directly followed by the trailer. `out_kind` is 0 when not valid. The cycle after the trailer is accepted, the block is idle.
- R5: `cfg_we` loads `cfg_len` into all three copies of the length setting at the edge. The new length governs packets from the next cycle on.
- R6: With `fault_en` high at an edge, `fault_mask` is XORed into the copy chosen by `fault_copy` (0, 1 or 2; the value 3 selects none). The voted outputs stay identical to a fault-free run. Mask bit positions: [CW-1:0] word counter, [CW+1:CW] phase (0 idle, 1 header, 2 body, 3 trailer), [2*CW+1:CW+2] length setting.
- R7: `mismatch` is high for exactly the one cycle after an edge at which a nonzero mask hit a copy, and low otherwise. The corrupted copy agrees again by the following edge, well within 3 cycles.
- R8: An injection with a zero mask, or with `fault_copy`=3, raises no `mismatch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one packet when idle |
| cfg_we | input | 1 | Write the body length setting |
| cfg_len | input | CW | New body length |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Stream word accepted |
| out_kind | output | 2 | Word type: 1 header, 2 body, 3 trailer |
| out_idx | output | CW | Body word index |
| busy | output | 1 | Packet in progress |
| mismatch | output | 1 | Copies disagree |
| fault_en | input | 1 | Inject a fault at this edge |
| fault_copy | input | 2 | Copy to corrupt (3 = none) |
| fault_mask | input | 2*CW+2 | Bits to flip in that copy |

## Verification
Every result of this block is due in the cycle that follows the edge that sampled its cause. Phase and index move one cycle after `start` or a handshake. The new length applies one cycle after `cfg_we`. `mismatch` rises in the cycle after an injection edge and falls one cycle later. The bench steps a behavioural model on each rising edge with the same inputs the design samples. It compares every port on the falling edge, half a period after the registers settle. The requirement named in each comparison follows the previous cycle's stimulus: a stall, an injection, a zero-mask injection or a length write.

// File: rtl/tmr_seq_pkg.sv
package tmr_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HEAD = 2'd1,
    PH_BODY = 2'd2,
    PH_TAIL = 2'd3
  } phase_t;
endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y,
  output logic         err
);
  always_comb begin
    y   = (a & b) | (a & c) | (b & c);
    err = (a != b) || (a != c);
  end
endmodule

// File: rtl/tmr_seq_copy.sv
module tmr_seq_copy
  import tmr_seq_pkg::*;
#(
  parameter int CW      = 4,
  parameter int DEF_LEN = 3,
  localparam int TW     = 2 * CW + 2,
  localparam int OW     = CW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] voted_st,
  input  logic          start,
  input  logic          out_ready,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_len,
  input  logic [TW-1:0] flip,
  output logic [TW-1:0] st_q,
  output logic [OW-1:0] outs
);
  localparam logic [CW-1:0] RST_LEN = CW'(DEF_LEN);

  logic [CW-1:0] v_len, v_cnt, n_len, n_cnt;
  phase_t        v_ph, n_ph, o_ph;
  logic [CW-1:0] o_cnt;

  always_comb begin
    v_len = voted_st[TW-1:CW+2];
    v_ph  = phase_t'(voted_st[CW+1:CW]);
    v_cnt = voted_st[CW-1:0];
    n_len = cfg_we ? cfg_len : v_len;
    n_ph  = v_ph;
    n_cnt = v_cnt;
    unique case (v_ph)
      PH_IDLE: if (start) begin
        n_ph  = PH_HEAD;
        n_cnt = '0;
      end
      PH_HEAD: if (out_ready) begin
        n_cnt = '0;
        n_ph  = (v_len == '0) ? PH_TAIL : PH_BODY;
      end
      PH_BODY: if (out_ready) begin
        if (v_cnt == v_len - 1'b1) begin
          n_ph  = PH_TAIL;
          n_cnt = '0;
        end else begin
          n_cnt = v_cnt + 1'b1;
        end
      end
      PH_TAIL: if (out_ready) n_ph = PH_IDLE;
      default: n_ph = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= {RST_LEN, PH_IDLE, {CW{1'b0}}};
    else        st_q <= {n_len, n_ph, n_cnt} ^ flip;
  end

  // Each copy decodes its own outputs; they are voted in the top.
  always_comb begin
    o_ph  = phase_t'(st_q[CW+1:CW]);
    o_cnt = st_q[CW-1:0];
    outs  = {o_ph != PH_IDLE,
             o_ph,
             (o_ph == PH_BODY) ? o_cnt : {CW{1'b0}},
             o_ph != PH_IDLE};
  end
endmodule

// File: rtl/tmr_seq_top.sv
module tmr_seq_top
  import tmr_seq_pkg::*;
#(
  parameter int CW      = 4,
  parameter int DEF_LEN = 3,
  localparam int TW     = 2 * CW + 2,
  localparam int OW     = CW + 4,
  localparam int NCOPY  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_len,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_kind,
  output logic [CW-1:0] out_idx,
  output logic          busy,
  output logic          mismatch,
  input  logic          fault_en,
  input  logic [1:0]    fault_copy,
  input  logic [TW-1:0] fault_mask
);
  logic [TW-1:0] c_st  [NCOPY];
  logic [OW-1:0] c_out [NCOPY];
  logic [TW-1:0] voted_st;
  logic [OW-1:0] voted_out;
  logic          err_st, err_out;

  tmr_voter #(.W(TW)) u_vote_st (
    .a(c_st[0]), .b(c_st[1]), .c(c_st[2]), .y(voted_st), .err(err_st)
  );

  for (genvar i = 0; i < NCOPY; i++) begin : g_copy
    logic [TW-1:0] flip;
    assign flip = (fault_en && fault_copy == 2'(i)) ? fault_mask : '0;
    tmr_seq_copy #(.CW(CW), .DEF_LEN(DEF_LEN)) u_copy (
      .clk(clk), .rst_n(rst_n), .voted_st(voted_st), .start(start),
      .out_ready(out_ready), .cfg_we(cfg_we), .cfg_len(cfg_len),
      .flip(flip), .st_q(c_st[i]), .outs(c_out[i])
    );
  end

  tmr_voter #(.W(OW)) u_vote_out (
    .a(c_out[0]), .b(c_out[1]), .c(c_out[2]), .y(voted_out), .err(err_out)
  );

  assign {out_valid, out_kind, out_idx, busy} = voted_out;
  assign mismatch = err_st | err_out;

  // R7: with no injection at an edge, all copies agree afterwards
  assert_resync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_en |=> !mismatch);

  // R3: a stalled word holds
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_idx)));

  // R2: a packet opens with the header word
  assert_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (out_kind == 2'(PH_HEAD) && out_idx == '0));

  // R4: accepted trailer returns to idle
  assert_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_kind == 2'(PH_TAIL)) |=> !busy);

  // R6: when the copies agree, the vote equals any copy's outputs
  assert_vote_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mismatch |-> (voted_out == c_out[0]));
endmodule

// File: tb/tmr_seq_top_tb.sv
module tmr_seq_top_tb;
  localparam int CW = 4;
  localparam int TW = 2 * CW + 2;
  localparam int NCYC = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cfg_we = 1'b0, out_ready = 1'b0, fault_en = 1'b0;
  logic [CW-1:0] cfg_len = '0;
  logic [1:0] fault_copy = 2'd3;
  logic [TW-1:0] fault_mask = '0;
  logic out_valid, busy, mismatch;
  logic [1:0] out_kind;
  logic [CW-1:0] out_idx;

  int n_chk = 0, n_bad = 0;
  bit done = 0, run = 0;

  always #10 clk = ~clk;

  tmr_seq_top #(.CW(CW), .DEF_LEN(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_we(cfg_we), .cfg_len(cfg_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_idx(out_idx), .busy(busy), .mismatch(mismatch), .fault_en(fault_en),
    .fault_copy(fault_copy), .fault_mask(fault_mask)
  );

  // Behavioural reference: phase 0 idle, 1 header, 2 body, 3 trailer
  int m_ph = 0, m_cnt = 0, m_len = 3;
  bit m_mm = 0, p_stall = 0, p_fault = 0, p_zero = 0, p_cfg = 0, p_sb = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph <= 0; m_cnt <= 0; m_len <= 3; m_mm <= 0;
      p_stall <= 0; p_fault <= 0; p_zero <= 0; p_cfg <= 0; p_sb <= 0;
    end else begin
      m_mm    <= fault_en && fault_copy != 2'd3 && fault_mask != '0;
      p_fault <= fault_en;
      p_zero  <= fault_en && (fault_mask == '0 || fault_copy == 2'd3);
      p_stall <= (m_ph != 0) && !out_ready;
      p_cfg   <= cfg_we;
      p_sb    <= (m_ph != 0) && start;
      if (cfg_we) m_len <= cfg_len;
      case (m_ph)
        0: if (start) begin m_ph <= 1; m_cnt <= 0; end
        1: if (out_ready) begin m_cnt <= 0; m_ph <= (m_len == 0) ? 3 : 2; end
        2: if (out_ready) begin
             if (m_cnt == m_len - 1) begin m_ph <= 3; m_cnt <= 0; end
             else m_cnt <= m_cnt + 1;
           end
        default: if (out_ready) m_ph <= 0;
      endcase
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int exp_word();
    int v, k, ix;
    v  = (m_ph != 0) ? 1 : 0;
    k  = m_ph;
    ix = (m_ph == 2) ? m_cnt : 0;
    return (v << 8) | (k << 4) | ix;
  endfunction

  always @(negedge clk) begin
    if (run) begin
      string t;
      t = p_stall ? "R3" : (p_fault ? "R6" : (p_cfg ? "R5" : "R4"));
      chk(t, (int'(out_valid) << 8) | (int'(out_kind) << 4) | int'(out_idx), exp_word());
      chk("R2", int'(busy), (m_ph != 0) ? 1 : 0);
      chk(p_zero ? "R8" : "R7", int'(mismatch), int'(m_mm));
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {out_valid, out_kind, out_idx, busy, mismatch}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {out_valid, out_kind, out_idx, busy, mismatch}, 0);
    run = 1;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      #1;
      out_ready  = (cyc < 200) ? 1'b1 : ($urandom_range(0, 3) != 0);
      start      = ($urandom_range(0, 5) == 0);
      cfg_we     = 1'b0;
      if (m_ph == 0 && !start && $urandom_range(0, 7) == 0) begin
        cfg_we  = 1'b1;
        cfg_len = CW'($urandom_range(0, 5));
      end
      fault_en   = (cyc > 50) && ($urandom_range(0, 4) == 0);
      fault_copy = 2'($urandom_range(0, 3));
      fault_mask = ($urandom_range(0, 5) == 0) ? '0 : TW'($urandom_range(1, (1 << TW) - 1));
    end
    fault_en = 1'b0;
    repeat (3) @(negedge clk);
    run = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * (NCYC + 1000));
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule